// File: doc/BRIEF.md
# Ownership-Tracking Snoop Coherence Controller

This block keeps one private cache coherent with its peers on a shared snooping bus. Every line carries one of four states: invalid, unowned-shared, owned-shared and owned-exclusive. A cache that holds a line in either owned state is answerable for it. It hands the data straight to another cache that misses on that line, and it writes the line back to memory when the line leaves. Memory may therefore hold stale data while other caches keep unowned-shared copies. Such copies are dropped silently on replacement.

The CPU side takes one request at a time (read or write to a line address). It answers with a one-cycle done pulse, a hit flag and the state the line holds after the access. The bus side has two parts. The first issues this cache's own transactions (read, read-for-ownership, invalidate, write-back) and waits for an external grant and, for fills, a fill strobe. The second watches the transactions of other caches and raises a supply flag one cycle later when this cache must drive the data. Asserting supply also tells memory to stay silent for that transaction. The directory is direct-mapped, with a parameterised number of sets, and holds tags and states only. The data array and the bus arbiter live elsewhere.

The CPU controller states are IDLE (lookup on request), UPGRADE (invalidate pending), WRBACK (victim write-back pending), FETCH (read or read-for-ownership pending), FILL (waiting for data) and RESP (done pulse). Transitions:
- IDLE→RESP on a read hit or on a write hit to owned-exclusive.
- IDLE→UPGRADE on a write hit to a shared line.
- IDLE→WRBACK on a miss whose victim is owned.
- IDLE→FETCH on any other miss.
- UPGRADE→RESP on grant, or UPGRADE→FETCH when the line was lost to a snoop.
- WRBACK→FETCH on grant, or when the victim lost ownership.
- FETCH→FILL on grant.
- FILL→RESP on the fill strobe.
- RESP→IDLE.

Top module: `own_coh_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is 1, and `bus_req` and `snp_supply` are 0. The first access to any address misses.
- R2: A read miss issues one bus read (command code 0) to the request address. On the fill strobe the line becomes unowned-shared (state code 1) and the response shows hit 0.
- R3: A read that hits a line in any valid state issues no bus transaction, leaves the state unchanged and responds with hit 1.
- R4: A write that hits an unowned-shared or owned-shared line (code 2) issues an invalidate (command code 2) to the request address. After the grant the line is owned-exclusive (code 3).
- R5: A write that hits an owned-exclusive line issues no bus transaction and the line stays owned-exclusive.
- R6: A write miss issues a read-for-ownership (command code 1). On the fill strobe the line becomes owned-exclusive, with hit 0.
- R7: A snooped read (code 0) whose tag matches an owned line raises `snp_supply` in the next cycle. Owned-exclusive becomes owned-shared and owned-shared stays owned-shared.
- R8: A snooped read that matches an unowned-shared line raises no supply and leaves the line unowned-shared.
- R9: A snooped read-for-ownership or invalidate that matches a line makes it invalid (state code 0). Supply is raised in the next cycle only if the line was owned.
- R10: On a miss whose victim is owned, a write-back (command code 3) to the victim's address precedes the fetch. An unowned-shared victim is replaced with no write-back.
- R11: If the victim loses ownership to a snoop while its write-back waits for a grant, the write-back is withdrawn and only the fetch is issued.
- R12: A snooped write-back, or a snoop whose tag does not match, raises no supply and changes no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Line address of the request |
| cpu_ready | output | 1 | Controller idle, request accepted this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request hit at lookup (valid with done) |
| cpu_line_state | output | 2 | Line state after the access (valid with done) |
| bus_req | output | 1 | Own bus transaction pending |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_addr | output | AW | Address of the own transaction |
| bus_grant | input | 1 | Bus granted to this cache this cycle |
| bus_fill_valid | input | 1 | Fill data for the pending read arrives |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as `bus_cmd` |
| snp_addr | input | AW | Snooped line address |
| snp_supply | output | 1 | This cache drives the data; memory must not answer |

## Verification
The bench aims at the ownership corners. A write to a shared line that skips the invalidate would leave stale peers. A snooped read on an owned-exclusive line that never moves it to owned-shared would let a later write go out with no invalidate. A snooped read-for-ownership that supplies from an unowned copy would put two drivers on the bus. On replacement it checks that owned victims are written back and unowned-shared victims are not, since an extra write-back would show up as an unexpected bus transaction. It also checks the race where a victim is taken by a snoop while its write-back waits: a controller that did not recheck would write back data it no longer owns.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_OSH = 2'd2,
        LS_OEX = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_READ = 2'd0,
        BC_RFO  = 2'd1,
        BC_INV  = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    function automatic logic is_owned(line_st_e s);
        return (s == LS_OSH) || (s == LS_OEX);
    endfunction

endpackage

// File: rtl/occ_dir.sv
module occ_dir
    import occ_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output line_st_e         a_st,
    output logic [TAG_W-1:0] a_tag,
    input  logic [IDX_W-1:0] b_idx,
    output line_st_e         b_st,
    output logic [TAG_W-1:0] b_tag,
    input  logic             s_we,
    input  logic [IDX_W-1:0] s_idx,
    input  line_st_e         s_st,
    input  logic             c_we,
    input  logic [IDX_W-1:0] c_idx,
    input  logic [TAG_W-1:0] c_tag,
    input  line_st_e         c_st
);
    localparam int SETS = 1 << IDX_W;

    line_st_e         st_arr  [SETS];
    logic [TAG_W-1:0] tag_arr [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        line_st_e         st_r;
        logic [TAG_W-1:0] tag_r;

        // snoop update wins over a CPU update of the same set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_r  <= LS_INV;
                tag_r <= '0;
            end else if (s_we && s_idx == MY_IDX) begin
                st_r <= s_st;
            end else if (c_we && c_idx == MY_IDX) begin
                st_r  <= c_st;
                tag_r <= c_tag;
            end
        end

        assign st_arr[g]  = st_r;
        assign tag_arr[g] = tag_r;
    end

    assign a_st  = st_arr[a_idx];
    assign a_tag = tag_arr[a_idx];
    assign b_st  = st_arr[b_idx];
    assign b_tag = tag_arr[b_idx];

endmodule

// File: rtl/occ_snoop.sv
module occ_snoop
    import occ_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [AW-1:0]    snp_addr,
    output logic [IDX_W-1:0] d_idx,
    input  line_st_e         d_st,
    input  logic [AW-IDX_W-1:0] d_tag,
    output logic             upd_we,
    output line_st_e         upd_st,
    output logic             snp_supply
);
    localparam int TAG_W = AW - IDX_W;

    logic [TAG_W-1:0] s_tag;
    logic             match;
    logic             supply_d;
    bus_cmd_e         cmd;

    assign d_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[AW-1:IDX_W];
    assign cmd   = bus_cmd_e'(snp_cmd);
    assign match = snp_valid && (d_st != LS_INV) && (d_tag == s_tag);

    always_comb begin
        upd_we   = 1'b0;
        upd_st   = d_st;
        supply_d = 1'b0;
        if (match) begin
            unique case (cmd)
                BC_READ: begin
                    supply_d = is_owned(d_st);
                    upd_we   = (d_st == LS_OEX);
                    upd_st   = LS_OSH;
                end
                BC_RFO, BC_INV: begin
                    supply_d = is_owned(d_st);
                    upd_we   = 1'b1;
                    upd_st   = LS_INV;
                end
                BC_WB: begin
                    upd_we = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snp_supply <= 1'b0;
        else        snp_supply <= supply_d;
    end

    // R7
    r7_owner_supplies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && cmd == BC_READ && d_tag == s_tag && is_owned(d_st)) |=> snp_supply);

    // R8
    r8_shared_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && cmd == BC_READ && d_st == LS_SHR) |=> !snp_supply);

    // R12
    r12_wb_snoop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && cmd == BC_WB) |=> !snp_supply);

    // R9
    r9_kill_leaves_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (cmd == BC_RFO || cmd == BC_INV) && d_tag == s_tag && d_st != LS_INV)
        |=> ($past(d_idx) != d_idx || d_st == LS_INV));

endmodule

// File: rtl/occ_cpu_fsm.sv
module occ_cpu_fsm
    import occ_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic             cpu_write,
    input  logic [AW-1:0]    cpu_addr,
    output logic             cpu_ready,
    output logic             cpu_done,
    output logic             cpu_hit,
    output line_st_e         cpu_st,
    output logic [IDX_W-1:0] lk_idx,
    input  line_st_e         lk_st,
    input  logic [AW-IDX_W-1:0] lk_tag,
    output logic             cw_we,
    output logic [AW-IDX_W-1:0] cw_tag,
    output line_st_e         cw_st,
    output logic             bus_req,
    output bus_cmd_e         bus_cmd,
    output logic [AW-1:0]    bus_addr,
    input  logic             bus_grant,
    input  logic             bus_fill_valid
);
    localparam int TAG_W = AW - IDX_W;

    typedef enum logic [2:0] {
        C_IDLE, C_UPGRADE, C_WRBACK, C_FETCH, C_FILL, C_RESP
    } cst_e;

    cst_e             cs_q, cs_d;
    logic [AW-1:0]    addr_q;
    logic             wr_q, hit_q;
    logic [TAG_W-1:0] vtag_q;

    logic [AW-1:0]    cur_addr;
    logic [TAG_W-1:0] cur_tag;
    logic             lk_hit, victim_owned;

    assign cur_addr     = (cs_q == C_IDLE) ? cpu_addr : addr_q;
    assign lk_idx       = cur_addr[IDX_W-1:0];
    assign cur_tag      = cur_addr[AW-1:IDX_W];
    assign lk_hit       = (lk_st != LS_INV) && (lk_tag == cur_tag);
    assign victim_owned = is_owned(lk_st) && (lk_tag == vtag_q);

    // next-state logic
    always_comb begin
        cs_d = cs_q;
        unique case (cs_q)
            C_IDLE: if (cpu_valid) begin
                if (lk_hit) begin
                    if (!cpu_write || lk_st == LS_OEX) cs_d = C_RESP;
                    else                               cs_d = C_UPGRADE;
                end else if (is_owned(lk_st)) begin
                    cs_d = C_WRBACK;
                end else begin
                    cs_d = C_FETCH;
                end
            end
            C_UPGRADE: begin
                if (!lk_hit)        cs_d = C_FETCH;
                else if (bus_grant) cs_d = C_RESP;
            end
            C_WRBACK: begin
                if (!victim_owned || bus_grant) cs_d = C_FETCH;
            end
            C_FETCH:  if (bus_grant)      cs_d = C_FILL;
            C_FILL:   if (bus_fill_valid) cs_d = C_RESP;
            C_RESP:   cs_d = C_IDLE;
            default:  cs_d = C_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= C_IDLE;
            addr_q <= '0;
            wr_q   <= 1'b0;
            hit_q  <= 1'b0;
            vtag_q <= '0;
        end else begin
            cs_q <= cs_d;
            if (cs_q == C_IDLE && cpu_valid) begin
                addr_q <= cpu_addr;
                wr_q   <= cpu_write;
                hit_q  <= lk_hit;
                vtag_q <= lk_tag;
            end else if (cs_q == C_UPGRADE && !lk_hit) begin
                hit_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        cpu_ready = (cs_q == C_IDLE);
        cpu_done  = (cs_q == C_RESP);
        cpu_hit   = hit_q;
        cpu_st    = lk_st;
        bus_req   = 1'b0;
        bus_cmd   = BC_READ;
        bus_addr  = addr_q;
        cw_we     = 1'b0;
        cw_tag    = cur_tag;
        cw_st     = LS_INV;
        unique case (cs_q)
            C_UPGRADE: begin
                bus_req = lk_hit;
                bus_cmd = BC_INV;
                cw_we   = lk_hit && bus_grant;
                cw_st   = LS_OEX;
            end
            C_WRBACK: begin
                bus_req  = victim_owned;
                bus_cmd  = BC_WB;
                bus_addr = {vtag_q, addr_q[IDX_W-1:0]};
                cw_we    = victim_owned && bus_grant;
                cw_tag   = vtag_q;
                cw_st    = LS_INV;
            end
            C_FETCH: begin
                bus_req = 1'b1;
                bus_cmd = wr_q ? BC_RFO : BC_READ;
            end
            C_FILL: begin
                cw_we = bus_fill_valid;
                cw_st = wr_q ? LS_OEX : LS_SHR;
            end
            default: begin
                bus_req = 1'b0;
            end
        endcase
    end

    // R4
    r4_upgrade_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == BC_INV && bus_grant) |=> (cpu_done && cpu_st == LS_OEX));

    // R6
    r6_rfo_fill_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q == C_FILL && bus_fill_valid && wr_q) |=> (cpu_done && cpu_st == LS_OEX));

    // R2
    r2_read_fill_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q == C_FILL && bus_fill_valid && !wr_q) |=> (cpu_done && cpu_st == LS_SHR));

    // R1
    r1_done_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> cpu_ready);

endmodule

// File: rtl/own_coh_ctrl.sv
module own_coh_ctrl
    import occ_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IDX_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_valid,
    input  logic          cpu_write,
    input  logic [AW-1:0] cpu_addr,
    output logic          cpu_ready,
    output logic          cpu_done,
    output logic          cpu_hit,
    output logic [1:0]    cpu_line_state,
    output logic          bus_req,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_grant,
    input  logic          bus_fill_valid,
    input  logic          snp_valid,
    input  logic [1:0]    snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_supply
);
    localparam int TAG_W = AW - IDX_W;

    logic [IDX_W-1:0] lk_idx, sn_idx;
    line_st_e         lk_st, sn_st, cw_st, up_st, cpu_st;
    logic [TAG_W-1:0] lk_tag, sn_tag, cw_tag;
    logic             cw_we, up_we;
    bus_cmd_e         bcmd;

    occ_dir #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .a_idx(lk_idx), .a_st(lk_st), .a_tag(lk_tag),
        .b_idx(sn_idx), .b_st(sn_st), .b_tag(sn_tag),
        .s_we(up_we), .s_idx(sn_idx), .s_st(up_st),
        .c_we(cw_we), .c_idx(lk_idx), .c_tag(cw_tag), .c_st(cw_st)
    );

    occ_snoop #(.AW(AW), .IDX_W(IDX_W)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .d_idx(sn_idx), .d_st(sn_st), .d_tag(sn_tag),
        .upd_we(up_we), .upd_st(up_st), .snp_supply(snp_supply)
    );

    occ_cpu_fsm #(.AW(AW), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_st(cpu_st),
        .lk_idx(lk_idx), .lk_st(lk_st), .lk_tag(lk_tag),
        .cw_we(cw_we), .cw_tag(cw_tag), .cw_st(cw_st),
        .bus_req(bus_req), .bus_cmd(bcmd), .bus_addr(bus_addr),
        .bus_grant(bus_grant), .bus_fill_valid(bus_fill_valid)
    );

    assign bus_cmd        = bcmd;
    assign cpu_line_state = cpu_st;

    // R5
    r5_owned_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && cpu_write && lk_st == LS_OEX
         && lk_tag == cpu_addr[AW-1:IDX_W]) |=> (!bus_req && cpu_done));

    // R3
    r3_read_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && !cpu_write && lk_st != LS_INV
         && lk_tag == cpu_addr[AW-1:IDX_W]) |=> (!bus_req && cpu_done && cpu_hit));

    // R10
    r10_wb_only_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_grant && bcmd == BC_WB) |=> !(bus_req && bcmd == BC_WB));

endmodule

// File: tb/own_coh_ctrl_tb.sv
`timescale 1ns/1ps
module own_coh_ctrl_tb;
    localparam int AW = 16;

    localparam logic [1:0] ST_I = 2'd0, ST_US = 2'd1, ST_OS = 2'd2, ST_OE = 2'd3;
    localparam logic [1:0] C_RD = 2'd0, C_RFO = 2'd1, C_INV = 2'd2, C_WB = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready, cpu_done, cpu_hit;
    logic [1:0]    cpu_line_state;
    logic          bus_req;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic          bus_grant = 1'b0, bus_fill_valid = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_supply;

    always #2.5 clk = ~clk;

    own_coh_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit),
        .cpu_line_state(cpu_line_state),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_grant(bus_grant), .bus_fill_valid(bus_fill_valid),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_supply(snp_supply)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit hold_grant = 1'b0;
    int fill_cnt = 0;

    logic [AW+1:0] bus_exp [$];
    string         bus_tag [$];
    logic [2:0]    rsp_exp [$];
    string         rsp_tag [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bus responder and transaction monitor
    initial begin
        forever begin
            @(negedge clk);
            bus_fill_valid = 1'b0;
            if (fill_cnt > 0) begin
                fill_cnt--;
                if (fill_cnt == 0) bus_fill_valid = 1'b1;
            end
            if (bus_grant) begin
                bus_grant = 1'b0;
            end else if (bus_req && !hold_grant) begin
                if (bus_exp.size() == 0) begin
                    check(1'b0, "R10", "unexpected bus transaction", int'({bus_cmd, bus_addr}), 0);
                end else begin
                    automatic logic [AW+1:0] e = bus_exp.pop_front();
                    automatic string t = bus_tag.pop_front();
                    check({bus_cmd, bus_addr} == e, t, "bus transaction",
                          int'({bus_cmd, bus_addr}), int'(e));
                end
                bus_grant = 1'b1;
                if (bus_cmd == C_RD || bus_cmd == C_RFO) fill_cnt = 2;
            end
        end
    end

    // response monitor
    initial begin
        forever begin
            @(negedge clk);
            if (cpu_done) begin
                if (rsp_exp.size() == 0) begin
                    check(1'b0, "R3", "unexpected response", int'({cpu_hit, cpu_line_state}), 0);
                end else begin
                    automatic logic [2:0] e = rsp_exp.pop_front();
                    automatic string t = rsp_tag.pop_front();
                    check({cpu_hit, cpu_line_state} == e, t, "cpu response {hit,state}",
                          int'({cpu_hit, cpu_line_state}), int'(e));
                end
            end
        end
    end

    task automatic expect_bus(input logic [1:0] cmd, input logic [AW-1:0] a, input string t);
        bus_exp.push_back({cmd, a});
        bus_tag.push_back(t);
    endtask

    task automatic cpu_issue(input bit wr, input logic [AW-1:0] a, input string t,
                             input bit ehit, input logic [1:0] est);
        rsp_exp.push_back({ehit, est});
        rsp_tag.push_back(t);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_valid = 1'b1;
        cpu_write = wr;
        cpu_addr  = a;
        @(negedge clk);
        cpu_valid = 1'b0;
    endtask

    task automatic cpu_wait();
        while (rsp_exp.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cpu_op(input bit wr, input logic [AW-1:0] a, input string t,
                          input bit ehit, input logic [1:0] est);
        cpu_issue(wr, a, t, ehit, est);
        cpu_wait();
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] a,
                         input bit esup, input string t);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_cmd   = cmd;
        snp_addr  = a;
        @(negedge clk);
        snp_valid = 1'b0;
        check(snp_supply == esup, t, "snoop supply", int'(snp_supply), int'(esup));
    endtask

    localparam logic [AW-1:0] LA = 16'h0011, LB = 16'h0022, LB2 = 16'h00A2;
    localparam logic [AW-1:0] LC = 16'h0033, LD = 16'h0133, LE = 16'h0233;
    localparam logic [AW-1:0] LF = 16'h0044, LG = 16'h0144;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cpu_ready == 1'b1, "R1", "cpu_ready after reset", int'(cpu_ready), 1);
        check(bus_req == 1'b0, "R1", "bus_req after reset", int'(bus_req), 0);
        check(snp_supply == 1'b0, "R1", "snp_supply after reset", int'(snp_supply), 0);

        // R2 read miss fills unowned-shared
        expect_bus(C_RD, LA, "R2");
        cpu_op(1'b0, LA, "R2", 1'b0, ST_US);
        // R3 read hit, no bus
        cpu_op(1'b0, LA, "R3", 1'b1, ST_US);
        // R8 snooped read on unowned-shared
        snoop(C_RD, LA, 1'b0, "R8");
        cpu_op(1'b0, LA, "R8", 1'b1, ST_US);
        // R4 write to unowned-shared upgrades
        expect_bus(C_INV, LA, "R4");
        cpu_op(1'b1, LA, "R4", 1'b1, ST_OE);
        // R5 write to owned-exclusive stays quiet
        cpu_op(1'b1, LA, "R5", 1'b1, ST_OE);
        // R7 snooped read on owned lines
        snoop(C_RD, LA, 1'b1, "R7");
        cpu_op(1'b0, LA, "R7", 1'b1, ST_OS);
        snoop(C_RD, LA, 1'b1, "R7");
        cpu_op(1'b0, LA, "R7", 1'b1, ST_OS);
        // R4 write to owned-shared upgrades
        expect_bus(C_INV, LA, "R4");
        cpu_op(1'b1, LA, "R4", 1'b1, ST_OE);
        // R9 snooped RFO on owned line
        snoop(C_RFO, LA, 1'b1, "R9");
        expect_bus(C_RD, LA, "R9");
        cpu_op(1'b0, LA, "R9", 1'b0, ST_US);

        // R6 write miss
        expect_bus(C_RFO, LB, "R6");
        cpu_op(1'b1, LB, "R6", 1'b0, ST_OE);
        // R9 snooped invalidate on owned line
        snoop(C_INV, LB, 1'b1, "R9");
        expect_bus(C_RD, LB, "R9");
        cpu_op(1'b0, LB, "R9", 1'b0, ST_US);
        // R9 invalidate on unowned copy: no supply
        snoop(C_INV, LB, 1'b0, "R9");
        expect_bus(C_RD, LB, "R9");
        cpu_op(1'b0, LB, "R9", 1'b0, ST_US);
        // R12 write-back snoop and tag mismatch
        snoop(C_WB, LB, 1'b0, "R12");
        cpu_op(1'b0, LB, "R12", 1'b1, ST_US);
        snoop(C_RFO, LB2, 1'b0, "R12");
        cpu_op(1'b0, LB, "R12", 1'b1, ST_US);

        // R10 owned victim written back, shared victim dropped
        expect_bus(C_RFO, LC, "R6");
        cpu_op(1'b1, LC, "R6", 1'b0, ST_OE);
        expect_bus(C_WB, LC, "R10");
        expect_bus(C_RD, LD, "R10");
        cpu_op(1'b0, LD, "R10", 1'b0, ST_US);
        expect_bus(C_RD, LE, "R10");
        cpu_op(1'b0, LE, "R10", 1'b0, ST_US);

        // R11 victim stolen while write-back waits
        expect_bus(C_RFO, LF, "R6");
        cpu_op(1'b1, LF, "R6", 1'b0, ST_OE);
        hold_grant = 1'b1;
        expect_bus(C_RD, LG, "R11");
        cpu_issue(1'b0, LG, "R11", 1'b0, ST_US);
        repeat (2) @(negedge clk);
        check(bus_req && bus_cmd == C_WB && bus_addr == LF, "R11", "pending write-back",
              int'({bus_req, bus_cmd, bus_addr}), int'({1'b1, C_WB, LF}));
        snoop(C_RFO, LF, 1'b1, "R11");
        hold_grant = 1'b0;
        cpu_wait();
        repeat (4) @(negedge clk);
        check(bus_exp.size() == 0, "R10", "bus transactions left unseen", bus_exp.size(), 0);
        check(bus_req == 1'b0, "R11", "bus idle at end", int'(bus_req), 0);

        summary();
        $finish;
    end

endmodule